// File: doc/BRIEF.md
# Write Posting Burst Scheduler

This block sits between the agents that post memory writes and the memory controller's write port. Posted writes are kept in a small in-order buffer, and the block decides when to offer them so that read traffic keeps priority. When accumulation is switched on, the block does not send writes out one by one. It waits until a minimum batch of writes is pending, then releases them together during a pause in read traffic. When accumulation is switched off, everything pending is drained at once.

The pause in read traffic is found from three inputs. A read-ready level reports that a read is waiting. A read-accepted pulse marks each read the controller takes. A programmable turnaround count sets how many cycles must pass after the last accepted read before a write may follow. Once a batch has started, it runs until the buffer empties. It can be cut short by a read being accepted, but only after the minimum batch size has gone out. This means a few writes can stay posted for an unlimited time.

Top module: `wpost_sched`

## Requirements
- R1: The buffer holds at most DEPTH (8) writes. `enq_full` is high exactly when eight are pending. An enqueue offered while `enq_full` is high is dropped and never issued.
- R2: Writes leave on `wr_addr`/`wr_data` in the same order they were accepted on the enqueue port. A transfer happens on each cycle where both `wr_valid` and `wr_ready` are high.
- R3: With `accum_en` high and no batch running, `wr_valid` stays low while fewer than THRESH (4) writes are pending, for as long as that lasts.
- R4: With `accum_en` high, a batch starts only in a cycle where all of the following hold: `rd_ready` is low, `rd_accept` is low, the turnaround has elapsed, and at least four writes are pending. `wr_valid` rises in the next cycle.
- R5: Once a batch has started, `wr_valid` stays high until at least four writes have transferred, whatever the read inputs do.
- R6: A batch ends when the buffer becomes empty. It also ends when `rd_accept` is high in a cycle in which the batch's transfer count, including that cycle's transfer, reaches four or more. `wr_valid` is low from the next cycle on.
- R7: With `accum_en` low, `wr_valid` is high whenever any write is pending, independent of `rd_ready`, `rd_accept` and the turnaround.
- R8: The turnaround has elapsed in a cycle when `rd_accept` is low and at least `turn_cycles` clock edges have passed since the edge that closed the last cycle with `rd_accept` high. Example: with `turn_cycles` = 5 and a full batch waiting, `wr_valid` first rises seven cycles after the accept cycle.
- R9: After reset the buffer is empty, `wr_valid` and `enq_full` are low, and the turnaround counts as elapsed.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accum_en | input | 1 | 1 = hold writes and release them in batches, 0 = drain all pending writes |
| turn_cycles | input | TURN_W | Cycles required between the last accepted read and a write batch |
| rd_ready | input | 1 | A read is waiting to issue |
| rd_accept | input | 1 | The controller accepted a read this cycle |
| enq_valid | input | 1 | Producer offers a write |
| enq_addr | input | ADDR_W | Address of the offered write |
| enq_data | input | DATA_W | Data of the offered write |
| enq_full | output | 1 | Buffer full; the offered write is not taken |
| wr_valid | output | 1 | A write is offered to the controller |
| wr_addr | output | ADDR_W | Address of the offered write |
| wr_data | output | DATA_W | Data of the offered write |
| wr_ready | input | 1 | Controller takes the offered write this cycle |

## Verification
The assertions assume that the producer may present an enqueue while full. They also assume `rd_accept` may pulse at any time, without regard to `rd_ready`. They assume the controller may hold `wr_ready` low for any number of cycles. Finally, they assume `accum_en` stays steady over the stretches in which a batch is checked. The stimulus changes every input only a few nanoseconds after a rising edge. It toggles `accum_en` only between test phases. It holds `turn_cycles` constant through each turnaround measurement, so every predicted edge is a fixed cycle count from the read pulse.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic {
    ST_HOLD  = 1'b0,
    ST_BURST = 1'b1
  } burst_st_e;

endpackage

// File: rtl/wps_fifo.sv
module wps_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic [W-1:0]     slot_view [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_we;
    assign slot_we = push && (wr_ptr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= din;
    end
    assign slot_view[i] = slot_q;
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (push) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
    if (push && !pop)      occ_d = occ_q + 1'b1;
    else if (pop && !push) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  assign dout = slot_view[rd_ptr_q];
  assign occ  = occ_q;
  assign full = (occ_q == OCC_W'(DEPTH));

  // R1: never more entries than slots
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R1: a blocked offer leaves the level untouched when nothing drains
  a_r1_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> occ_q == $past(occ_q));

endmodule

// File: rtl/wps_gap_timer.sv
module wps_gap_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_accept,
  input  logic [CW-1:0] turn_cycles,
  output logic          turn_ok
);

  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] gap_q, gap_d;
  logic          gap_en;

  assign gap_en = rd_accept || (gap_q != SAT);

  always_comb begin
    gap_d = gap_q;
    if (rd_accept)         gap_d = '0;
    else if (gap_q != SAT) gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= SAT;
    else if (gap_en) gap_q <= gap_d;
  end

  assign turn_ok = !rd_accept && (gap_q >= turn_cycles);

  // R8: an accepted read restarts the interval
  a_r8_gap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> gap_q == '0);

endmodule

// File: rtl/wps_burst_ctl.sv
module wps_burst_ctl
  import wps_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int THRESH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accum_en,
  input  logic                        rd_ready,
  input  logic                        rd_accept,
  input  logic                        turn_ok,
  input  logic [$clog2(DEPTH+1)-1:0]  occ,
  input  logic                        push,
  input  logic                        pop,
  output logic                        wr_valid,
  output logic                        in_burst
);

  localparam int OCC_W = $clog2(DEPTH+1);
  localparam int BC_W  = $clog2(THRESH+1);

  burst_st_e        st_q, st_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d;
  logic [BC_W:0]    bc_sum;
  logic [OCC_W:0]   occ_next;
  logic             min_met;
  logic             start;

  assign bc_sum   = {1'b0, bcnt_q} + (BC_W+1)'(pop);
  assign min_met  = bc_sum >= (BC_W+1)'(THRESH);
  assign occ_next = {1'b0, occ} + (OCC_W+1)'(push) - (OCC_W+1)'(pop);
  assign start    = accum_en && !rd_ready && turn_ok && (occ >= OCC_W'(THRESH));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HOLD:  if (start) st_d = ST_BURST;
      ST_BURST: begin
        if (!accum_en)                 st_d = ST_HOLD;
        else if (occ_next == '0)       st_d = ST_HOLD;
        else if (rd_accept && min_met) st_d = ST_HOLD;
      end
      default:  st_d = ST_HOLD;
    endcase
  end

  always_comb begin
    bcnt_d = '0;
    if (st_q == ST_BURST && st_d == ST_BURST)
      bcnt_d = min_met ? BC_W'(THRESH) : bc_sum[BC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOLD;
      bcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign in_burst = (st_q == ST_BURST);
  assign wr_valid = (occ != '0) && (!accum_en || in_burst);

  // R4: a batch only opens after a cycle that met every start condition
  a_r4_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_burst) |-> $past(accum_en && !rd_ready && turn_ok && occ >= OCC_W'(THRESH)));

  // R5: the minimum batch keeps being offered
  a_r5_min_batch: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && accum_en && bcnt_q < BC_W'(THRESH) |-> wr_valid);

  // R6: a read accepted after the minimum closes the batch
  a_r6_read_stop: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst && accum_en && rd_accept && bcnt_q >= BC_W'(THRESH) |=> !in_burst);

endmodule

// File: rtl/wpost_sched.sv
module wpost_sched #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int THRESH = 4,
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accum_en,
  input  logic [TURN_W-1:0] turn_cycles,
  input  logic              rd_ready,
  input  logic              rd_accept,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [DATA_W-1:0] enq_data,
  output logic              enq_full,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ready
);

  localparam int ENT_W = ADDR_W + DATA_W;
  localparam int OCC_W = $clog2(DEPTH+1);

  logic             push, pop, full;
  logic             turn_ok, in_burst, issue;
  logic [OCC_W-1:0] occ;
  logic [ENT_W-1:0] head;

  assign push = enq_valid && !full;
  assign pop  = issue && wr_ready;

  wps_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_buf (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push),
    .din  ({enq_addr, enq_data}),
    .pop  (pop),
    .dout (head),
    .occ  (occ),
    .full (full)
  );

  wps_gap_timer #(.CW(TURN_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_accept  (rd_accept),
    .turn_cycles(turn_cycles),
    .turn_ok    (turn_ok)
  );

  wps_burst_ctl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accum_en (accum_en),
    .rd_ready (rd_ready),
    .rd_accept(rd_accept),
    .turn_ok  (turn_ok),
    .occ      (occ),
    .push     (push),
    .pop      (pop),
    .wr_valid (issue),
    .in_burst (in_burst)
  );

  assign enq_full = full;
  assign wr_valid = issue;
  assign wr_addr  = head[ENT_W-1:DATA_W];
  assign wr_data  = head[DATA_W-1:0];

  // R10: a stalled offer keeps its payload
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> $stable(wr_addr) && $stable(wr_data));

  // R7: drain mode offers whenever the buffer is full
  a_r7_drain_full: assert property (@(posedge clk) disable iff (!rst_n)
    !accum_en && enq_full |-> wr_valid);

endmodule

// File: tb/wpost_sched_test.sv
module wpost_sched_test;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          accum_en, rd_ready, rd_accept, enq_valid, wr_ready;
  logic [7:0]    turn_cycles;
  logic [AW-1:0] enq_addr;
  logic [DW-1:0] enq_data;
  logic          enq_full, wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int failures = 0;
  int xfers = 0;
  bit done = 1'b0;
  logic [AW+DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  wpost_sched uut (
    .clk(clk), .rst_n(rst_n), .accum_en(accum_en), .turn_cycles(turn_cycles),
    .rd_ready(rd_ready), .rd_accept(rd_accept), .enq_valid(enq_valid),
    .enq_addr(enq_addr), .enq_data(enq_data), .enq_full(enq_full),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic enq(input logic [AW-1:0] a, input logic [DW-1:0] d);
    enq_valid = 1'b1;
    enq_addr  = a;
    enq_data  = d;
    if (!enq_full) exp_q.push_back({a, d});
    cyc(1);
    enq_valid = 1'b0;
  endtask

  // monitor: scoreboard for every completed handshake (R2)
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      xfers++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "transfer with nothing expected", xfers, 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R2", "issue order addr",
              longint'(wr_addr), longint'(e[AW+DW-1:DW]));
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base;
    logic [AW-1:0] held;
    rst_n = 1'b0; accum_en = 1'b1; rd_ready = 1'b0; rd_accept = 1'b0;
    enq_valid = 1'b0; wr_ready = 1'b1; turn_cycles = 8'd0;
    enq_addr = '0; enq_data = '0;
    cyc(3);
    // R9: reset state
    check(wr_valid == 1'b0, "R9", "wr_valid after reset", wr_valid, 0);
    check(enq_full == 1'b0, "R9", "enq_full after reset", enq_full, 0);
    rst_n = 1'b1;
    cyc(1);

    // R3: three pending writes are never offered
    base = xfers;
    for (int i = 0; i < 3; i++) enq(32'h100 + i, 64'hA0 + i);
    cyc(20);
    check(xfers == base, "R3", "transfers with 3 pending", xfers - base, 0);
    check(wr_valid == 1'b0, "R3", "wr_valid with 3 pending", wr_valid, 0);

    // R4/R6: fourth write opens a batch that runs until empty (R9: turnaround elapsed from reset)
    enq(32'h103, 64'hA3);
    cyc(8);
    check(xfers == base + 4, "R6", "batch drained to empty", xfers - base, 4);
    check(exp_q.size() == 0, "R6", "scoreboard empty", exp_q.size(), 0);
    check(wr_valid == 1'b0, "R6", "wr_valid after empty", wr_valid, 0);

    // R4: a waiting read blocks the batch
    rd_ready = 1'b1;
    turn_cycles = 8'd5;
    base = xfers;
    for (int i = 0; i < 4; i++) enq(32'h200 + i, 64'hB0 + i);
    cyc(5);
    check(wr_valid == 1'b0, "R4", "blocked by rd_ready", wr_valid, 0);

    // R8: turnaround of 5 after an accepted read
    rd_ready = 1'b0;
    rd_accept = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      cyc(1);
      rd_accept = 1'b0;
      check(wr_valid == (k == 7), "R8", $sformatf("wr_valid %0d cycles after accept", k),
            wr_valid, (k == 7));
    end
    cyc(6);
    check(xfers == base + 4, "R8", "batch after turnaround", xfers - base, 4);

    // R5/R10: stalled batch holds its head, then a read stream cuts it after four
    turn_cycles = 8'd0;
    wr_ready = 1'b0;
    base = xfers;
    for (int i = 0; i < 6; i++) enq(32'h300 + i, 64'hC0 + i);
    cyc(2);
    check(wr_valid == 1'b1, "R5", "batch offered", wr_valid, 1);
    held = wr_addr;
    check(held == 32'h300, "R10", "head address", held, 32'h300);
    cyc(2);
    check(wr_addr == held, "R10", "address held while stalled", wr_addr, held);
    wr_ready = 1'b1;
    rd_ready = 1'b1;
    rd_accept = 1'b1;
    cyc(4);
    check(wr_valid == 1'b0, "R6", "wr_valid after read cut", wr_valid, 0);
    check(xfers == base + 4, "R5", "minimum batch under reads", xfers - base, 4);
    rd_accept = 1'b0;
    rd_ready = 1'b0;
    cyc(20);
    check(xfers == base + 4, "R3", "two left posted", xfers - base, 4);
    check(exp_q.size() == 2, "R3", "two expected remain", exp_q.size(), 2);

    // R7: drain mode ignores read traffic
    rd_ready = 1'b1;
    accum_en = 1'b0;
    cyc(1);
    check(wr_valid == 1'b1, "R7", "drain offers with read waiting", wr_valid, 1);
    cyc(4);
    check(xfers == base + 6, "R7", "all drained", xfers - base, 6);

    // R1: ninth offer while full is dropped
    wr_ready = 1'b0;
    base = xfers;
    for (int i = 0; i < 8; i++) enq(32'h400 + i, 64'hD0 + i);
    check(enq_full == 1'b1, "R1", "full at eight", enq_full, 1);
    enq(32'h4FF, 64'hDF);
    check(exp_q.size() == 8, "R1", "ninth not expected", exp_q.size(), 8);
    check(enq_full == 1'b1, "R1", "still full", enq_full, 1);
    wr_ready = 1'b1;
    cyc(14);
    check(xfers == base + 8, "R1", "exactly eight issued", xfers - base, 8);
    check(wr_valid == 1'b0, "R1", "nothing after eight", wr_valid, 0);
    check(enq_full == 1'b0, "R1", "full cleared", enq_full, 0);

    finish_run();
  end

endmodule